// File: doc/BRIEF.md
# Colour Subcarrier Phase Accumulator

This block produces the running phase of the colour subcarrier for a composite video encoder. A 32-bit accumulator advances by a programmable step on every enabled pixel-clock cycle and wraps modulo 2^32. The upper ten bits go to a downstream sine/cosine table. The step is written one byte at a time through a small write port. The staged bytes are applied as a single value only when the top byte is written, so the accumulator never runs on a half-written step.

The line and field strobes from the video timebase drive two more functions. The first is a choice of four schedules for forcing the phase back to zero: never, every second line, every fourth field or every eighth field. The second is an alternating-line switch for PAL chroma, which toggles at every line and can be inverted by a control bit.

Top module: `subcarrier_phase_gen`

## Requirements
- R1: After reset the phase output is 0, the internal line switch is 0 so `pal_sw` equals `pal_inv`, and the active step is 0x21F07C1F.
- R2: On each cycle with `pix_en` high and no phase clear, the 32-bit accumulator takes the value accumulator + step, modulo 2^32. The result appears at the outputs after that clock edge.
- R3: With `pix_en` low, the accumulator, the line switch, the line parity and the field count keep their values, and `line_start` and `field_start` are ignored.
- R4: Writing byte lanes 0, 1 and 2 (`inc_sel` 0 to 2, lane 0 least significant) only stages those bytes. Writing lane 3 loads {lane 3 data, staged lane 2, staged lane 1, staged lane 0} as the active step. The add made on the write edge itself uses the old step.
- R5: With `clr_mode` = 2'b00, the phase is never cleared.
- R6: With `clr_mode` = 2'b01, an enabled `line_start` clears the accumulator to 0 in place of the add when the line parity is even. The parity is 0 after reset and flips at every enabled `line_start`, whatever the mode.
- R7: With `clr_mode` = 2'b10, the accumulator is cleared on an enabled cycle where `line_start` and `field_start` are both high and the 3-bit field count after that strobe is 0. The count is 7 after reset and advances at every enabled `field_start`, so the first field after reset is field 0.
- R8: With `clr_mode` = 2'b11, the same rule as R7 applies, but it uses only the low 2 bits of the field count, which clears the phase every fourth field.
- R9: `phase_out` carries bits 31 down to 22 of the accumulator.
- R10: The line switch toggles on every enabled `line_start`. `pal_sw` is that switch XOR `pal_inv`, so `pal_inv` = 1 inverts the switch at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Clock enable, one pulse per pixel sample |
| inc_we | input | 1 | Step byte write strobe |
| inc_sel | input | 2 | Byte lane being written (3 = most significant, commits) |
| inc_data | input | 8 | Byte value being written |
| clr_mode | input | 2 | Phase clear schedule: 00 none, 01 two lines, 10 eight fields, 11 four fields |
| line_start | input | 1 | Strobe from the timebase at the first sample of a line |
| field_start | input | 1 | Strobe from the timebase at the first sample of a field |
| pal_inv | input | 1 | Inverts the PAL line switch |
| phase_out | output | 10 | Upper accumulator bits for the sine/cosine lookup |
| pal_sw | output | 1 | Current PAL line switch state |

## Verification
The field-based schedules assume that the timebase raises `field_start` only in the same cycle as a `line_start`, because the clear is tied to the first line of a field. The stimulus always pairs the two strobes this way, with a fixed number of lines between field strobes. The assertions also assume that the strobes matter only when `pix_en` is high. The stimulus therefore also raises strobes in disabled cycles, to show that they are ignored there.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int unsigned SCP_ACC_W = 32;
    localparam int unsigned SCP_PH_W  = 10;
    localparam int unsigned SCP_FLD_W = 3;

    localparam logic [SCP_ACC_W-1:0] SCP_STEP_DEFAULT = 32'h21F0_7C1F;

    typedef enum logic [1:0] {
        CLR_NEVER  = 2'b00,
        CLR_LINE2  = 2'b01,
        CLR_FIELD8 = 2'b10,
        CLR_FIELD4 = 2'b11
    } clr_mode_e;

    typedef struct packed {
        logic en;
        logic line;
        logic field;
    } tb_strobe_t;

    function automatic logic fld_hit(input logic [SCP_FLD_W-1:0] cnt,
                                     input logic use_short);
        logic [SCP_FLD_W-1:0] mask;
        mask = use_short ? {1'b0, {(SCP_FLD_W-1){1'b1}}} : {SCP_FLD_W{1'b1}};
        return (cnt & mask) == '0;
    endfunction

endpackage

// File: rtl/scp_step_reg.sv
module scp_step_reg
    import scp_pkg::*;
#(
    parameter int unsigned ACC_W = SCP_ACC_W,
    parameter logic [ACC_W-1:0] STEP_RST = SCP_STEP_DEFAULT,
    localparam int unsigned LANES = ACC_W / 8,
    localparam int unsigned SEL_W = $clog2(LANES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [7:0]       data,
    output logic [ACC_W-1:0] step
);

    localparam logic [SEL_W-1:0] TOP_LANE = SEL_W'(LANES - 1);

    logic [ACC_W-9:0] staged;

    for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                staged[g*8 +: 8] <= STEP_RST[g*8 +: 8];
            end else if (we && sel == SEL_W'(g)) begin
                staged[g*8 +: 8] <= data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step <= STEP_RST;
        end else if (we && sel == TOP_LANE) begin
            step <= {data, staged};
        end
    end

    // R4: the active step changes only on a write to the top lane
    a_r4_hold_until_top: assert property (@(posedge clk) disable iff (rst)
        !(we && sel == TOP_LANE) |=> $stable(step));

endmodule

// File: rtl/scp_clr_sched.sv
module scp_clr_sched
    import scp_pkg::*;
#(
    parameter int unsigned FLD_W = SCP_FLD_W
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      line_start,
    input  logic      field_start,
    input  clr_mode_e mode,
    output logic      clr,
    output logic      line_tick
);

    logic             parity;
    logic [FLD_W-1:0] fcnt;
    logic [FLD_W-1:0] fcnt_next;
    logic             fld_tick;

    assign line_tick = en & line_start;
    assign fld_tick  = en & field_start;
    assign fcnt_next = fld_tick ? fcnt + 1'b1 : fcnt;

    always_comb begin
        clr = 1'b0;
        if (line_tick) begin
            unique case (mode)
                CLR_NEVER:  clr = 1'b0;
                CLR_LINE2:  clr = ~parity;
                CLR_FIELD8: clr = field_start & fld_hit(fcnt_next, 1'b0);
                CLR_FIELD4: clr = field_start & fld_hit(fcnt_next, 1'b1);
                default:    clr = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            parity <= 1'b0;
            fcnt   <= '1;
        end else begin
            if (line_tick) parity <= ~parity;
            fcnt <= fcnt_next;
        end
    end

    // R5: no clear is ever requested in the never-clear mode
    a_r5_never_mode: assert property (@(posedge clk) disable iff (rst)
        (mode == CLR_NEVER) |-> !clr);

    // R6: two consecutive enabled line starts cannot both clear in two-line mode
    a_r6_alternate: assert property (@(posedge clk) disable iff (rst)
        (clr && mode == CLR_LINE2) |=> !(clr && $stable(mode)));

    // R3: counters are frozen without enable
    a_r3_sched_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(parity) && $stable(fcnt)));

endmodule

// File: rtl/scp_phase_acc.sv
module scp_phase_acc
    import scp_pkg::*;
#(
    parameter int unsigned ACC_W = SCP_ACC_W,
    parameter int unsigned PH_W  = SCP_PH_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             clr,
    input  logic             line_tick,
    input  logic [ACC_W-1:0] step,
    input  logic             inv,
    output logic [PH_W-1:0]  phase,
    output logic             sw
);

    logic [ACC_W-1:0] acc;
    logic             sw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            sw_q <= 1'b0;
        end else if (en) begin
            acc <= clr ? '0 : acc + step;
            if (line_tick) sw_q <= ~sw_q;
        end
    end

    assign phase = acc[ACC_W-1 -: PH_W];
    assign sw    = sw_q ^ inv;

    // R2: an enabled cycle without clear advances by the step, wrapping
    a_r2_step_add: assert property (@(posedge clk) disable iff (rst)
        (en && !clr) |=> acc == $past(acc) + $past(step));

    // R3: the accumulator holds when not enabled
    a_r3_acc_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(acc));

    // R6: a requested clear leaves zero behind
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (rst)
        (en && clr) |=> acc == '0);

    // R10: the line switch flips exactly on enabled line starts
    a_r10_switch_flip: assert property (@(posedge clk) disable iff (rst)
        (en && line_tick) |=> sw_q != $past(sw_q));

    a_r10_switch_keep: assert property (@(posedge clk) disable iff (rst)
        !(en && line_tick) |=> $stable(sw_q));

endmodule

// File: rtl/subcarrier_phase_gen.sv
module subcarrier_phase_gen
    import scp_pkg::*;
#(
    parameter int unsigned ACC_W = SCP_ACC_W,
    parameter int unsigned PH_W  = SCP_PH_W,
    parameter int unsigned FLD_W = SCP_FLD_W,
    localparam int unsigned SEL_W = $clog2(ACC_W / 8)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic             inc_we,
    input  logic [SEL_W-1:0] inc_sel,
    input  logic [7:0]       inc_data,
    input  logic [1:0]       clr_mode,
    input  logic             line_start,
    input  logic             field_start,
    input  logic             pal_inv,
    output logic [PH_W-1:0]  phase_out,
    output logic             pal_sw
);

    logic [ACC_W-1:0] step;
    logic             clr;
    logic             line_tick;
    clr_mode_e        mode;

    assign mode = clr_mode_e'(clr_mode);

    scp_step_reg #(.ACC_W(ACC_W)) i_step (
        .clk  (clk),
        .rst  (rst),
        .we   (inc_we),
        .sel  (inc_sel),
        .data (inc_data),
        .step (step)
    );

    scp_clr_sched #(.FLD_W(FLD_W)) i_sched (
        .clk         (clk),
        .rst         (rst),
        .en          (pix_en),
        .line_start  (line_start),
        .field_start (field_start),
        .mode        (mode),
        .clr         (clr),
        .line_tick   (line_tick)
    );

    scp_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) i_acc (
        .clk       (clk),
        .rst       (rst),
        .en        (pix_en),
        .clr       (clr),
        .line_tick (line_tick),
        .step      (step),
        .inv       (pal_inv),
        .phase     (phase_out),
        .sw        (pal_sw)
    );

    // R1: the first cycle after reset shows zero phase and nominal switch
    a_r1_reset_state: assert property (@(posedge clk)
        $fell(rst) |-> (phase_out == '0 && pal_sw == pal_inv));

endmodule

// File: tb/test_subcarrier_phase_gen.sv
module test_subcarrier_phase_gen;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_en = 1'b0;
    logic       inc_we = 1'b0;
    logic [1:0] inc_sel = 2'd0;
    logic [7:0] inc_data = 8'd0;
    logic [1:0] clr_mode = 2'd0;
    logic       line_start = 1'b0;
    logic       field_start = 1'b0;
    logic       pal_inv = 1'b0;
    logic [9:0] phase_out;
    logic       pal_sw;

    always #(CLK_PERIOD / 2) clk = ~clk;

    subcarrier_phase_gen i_subcarrier_phase_gen (
        .clk(clk), .rst(rst), .pix_en(pix_en), .inc_we(inc_we),
        .inc_sel(inc_sel), .inc_data(inc_data), .clr_mode(clr_mode),
        .line_start(line_start), .field_start(field_start),
        .pal_inv(pal_inv), .phase_out(phase_out), .pal_sw(pal_sw)
    );

    typedef struct {
        logic [9:0] ph;
        logic       sw;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;

    // reference model state
    logic [31:0] m_acc  = '0;
    logic [31:0] m_step = 32'h21F0_7C1F;
    logic [23:0] m_stg  = 24'hF0_7C1F;
    logic        m_par  = 1'b0;
    logic [2:0]  m_fc   = 3'd7;
    logic        m_sw   = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        cfg_inv  = 1'b0;

    task automatic check(input logic [9:0] ph, input logic sw, input exp_t e);
        n_cmp++;
        if (ph !== e.ph || sw !== e.sw) begin
            n_bad++;
            $display("FAIL %s: phase=%0d sw=%0b expected phase=%0d sw=%0b",
                     e.tag, ph, sw, e.ph, e.sw);
        end
    endtask

    // monitor: compare after each edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(phase_out, pal_sw, e);
        end
    end

    task automatic step(input logic en, input logic ls, input logic fs,
                        input logic we, input logic [1:0] sel,
                        input logic [7:0] d, input string tag);
        logic       clr;
        logic [2:0] fn;
        exp_t       e;
        @(negedge clk);
        pix_en = en; line_start = ls; field_start = fs;
        inc_we = we; inc_sel = sel; inc_data = d;
        clr_mode = cfg_mode; pal_inv = cfg_inv;
        if (en) begin
            fn  = fs ? m_fc + 3'd1 : m_fc;
            clr = 1'b0;
            if (ls) begin
                case (cfg_mode)
                    2'b01: clr = ~m_par;
                    2'b10: clr = fs && (fn == 3'd0);
                    2'b11: clr = fs && (fn[1:0] == 2'd0);
                    default: clr = 1'b0;
                endcase
            end
            m_acc = clr ? 32'd0 : m_acc + m_step;
            if (ls) begin m_par = ~m_par; m_sw = ~m_sw; end
            m_fc = fn;
        end
        if (we) begin
            if (sel == 2'd3) m_step = {d, m_stg};
            else m_stg[sel*8 +: 8] = d;
        end
        e.ph = m_acc[31:22];
        e.sw = m_sw ^ cfg_inv;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic run(input int cycles, input int line_len, input int lines_per_field,
                       input string tag);
        int pix  = 0;
        int line = 0;
        for (int i = 0; i < cycles; i++) begin
            logic ls, fs;
            ls = (pix == 0);
            fs = ls && (line == 0);
            step(1'b1, ls, fs && lines_per_field > 0, 1'b0, 2'd0, 8'd0, tag);
            pix++;
            if (pix == line_len) begin
                pix = 0;
                line++;
                if (lines_per_field > 0 && line == lines_per_field) line = 0;
            end
        end
    endtask

    task automatic write_step(input logic [31:0] v, input string tag);
        for (int b = 0; b < 4; b++)
            step(1'b1, 1'b0, 1'b0, 1'b1, 2'(b), v[b*8 +: 8], tag);
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        exp_t e0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        e0.ph = 10'd0; e0.sw = 1'b0; e0.tag = "R1 reset state";
        check(phase_out, pal_sw, e0);

        // R1 R2 R5 R9 R10: default step, no clearing, lines of 7
        cfg_mode = 2'b00;
        run(60, 7, 0, "R2 R5 R9 R10 default step");

        // R3: strobes with enable low are ignored
        for (int i = 0; i < 6; i++)
            step(1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 8'd0, "R3 disabled hold");

        // R4: staging lanes 0..2 leaves old step active
        step(1'b1, 1'b0, 1'b0, 1'b1, 2'd0, 8'hCB, "R4 stage lane0");
        step(1'b1, 1'b0, 1'b0, 1'b1, 2'd1, 8'h8A, "R4 stage lane1");
        step(1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 8'h09, "R4 stage lane2");
        run(5, 100, 0, "R4 old step still used");
        step(1'b1, 1'b0, 1'b0, 1'b1, 2'd3, 8'h2A, "R4 commit lane3");
        run(20, 100, 0, "R4 new step applied");

        // R10: inverted switch
        cfg_inv = 1'b1;
        run(30, 5, 0, "R10 inverted switch");
        cfg_inv = 1'b0;

        // R6: clear every second line
        cfg_mode = 2'b01;
        run(80, 9, 0, "R6 two-line clear");

        // R7: eight-field clear, 3 lines of 6 per field
        cfg_mode = 2'b10;
        run(6 * 3 * 12, 6, 3, "R7 eight-field clear");

        // R8: four-field clear
        cfg_mode = 2'b11;
        run(6 * 3 * 10, 6, 3, "R8 four-field clear");

        // R2: wrap with a large step
        cfg_mode = 2'b00;
        write_step(32'hC000_0001, "R2 wrap step load");
        run(20, 50, 0, "R2 wrap modulo");

        @(negedge clk);
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule